// File: doc/BRIEF.md
# Late-Allocating Memory-Op Tracking Queue

This block keeps track of memory operations in flight in an out-of-order core. It has two circular rings of slots: one for loads and one for stores. A memory op takes a slot only when the scheduler sends it to execute. Entering the scheduler or waiting in front of it does not take a slot. When the ring for an op's kind has no free slot, the block refuses the request, and the op stays in the scheduler until a later cycle.

Slots are returned before retirement. The commit logic supplies a boundary tag. Every op at or older than that tag is non-speculative: no unresolved branch and no unresolved memory address lies ahead of it. The block frees slots strictly in program order, merged across both rings, and frees at most two per cycle. An op younger than the boundary, or one with an older op still holding a slot, keeps its slot.

A flush names a tag. Every slot holding a strictly younger op is freed at the next edge, and the write pointers move back over the freed slots. Program-order tags are 9 bits wide and are compared modulo 512, so numbering wraps without trouble while fewer than 256 tags are live.

Top module: `lsq_late_alloc`

## Requirements
- R1: After reset every bit of `lq_busy` and `sq_busy` is 0, and `lq_full` and `sq_full` are 0.
- R2: A granted issue takes the next slot of its own ring in ring order. The first slot after reset is index 0, and after the last index the ring wraps to index 0. The slot's bit in `lq_busy` (load, `issue_is_store`=0) or `sq_busy` (store, `issue_is_store`=1) reads 1 from the next edge onward. The scheduler issues each kind in program order.
- R3: The full flag of a ring is 1 while every slot of that ring is busy. While that ring releases nothing in the same cycle, an issue of that kind sees `issue_grant`=0 and the busy vector is unchanged. An issue of the other kind is still granted.
- R4: A slot is freed only if its tag is equal to or older than `nonspec_tag`. Younger slots stay busy.
- R5: Slots are freed in program order across both rings. A slot is freed only after every older slot in either ring has been freed.
- R6: At most 2 slots are freed per cycle, summed over both rings.
- R7: On a full ring, a release and an issue of the same kind in one cycle are both performed.
- R8: With `flush_valid`=1, every slot whose tag is strictly younger than `flush_tag` is freed at the next edge, and the slot holding `flush_tag` is kept. In that cycle `issue_grant` is 0 and no release happens. The next granted op of a kind takes the first slot freed in its ring.
- R9: Tag age is taken modulo 512: a is younger than b when (a−b) mod 512 lies in 1..255. Release and flush therefore behave correctly across the wrap from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Scheduler asks to issue a memory op |
| issue_is_store | input | 1 | 1 = store, 0 = load |
| issue_tag | input | 9 | Program-order tag of the op |
| issue_grant | output | 1 | Slot granted; the op may leave the scheduler |
| nonspec_tag | input | 9 | Youngest tag known to be non-speculative |
| flush_valid | input | 1 | Discard ops younger than `flush_tag` |
| flush_tag | input | 9 | Youngest surviving tag of a flush |
| lq_busy | output | 130 | Per-slot occupancy of the load ring |
| sq_busy | output | 60 | Per-slot occupancy of the store ring |
| lq_full | output | 1 | Every load slot is busy |
| sq_full | output | 1 | Every store slot is busy |

## Verification
The bench checks release with several tag mixes:
- A load and a store that are both eligible, which shows that both rings drain in one cycle.
- A run of three stores ahead of a younger eligible load, which separates program-order merging from per-ring draining and shows the two-per-cycle limit.
- A boundary that covers only part of the slots, which shows that younger ops keep their slots.

Filling the load ring completely checks refusal against the full flag, the store ring still accepting while the load ring is full, and the same-cycle free-and-reuse case. A flush placed in the middle of interleaved loads and stores checks the trim, the rewind, and the blocked release. A final run of tags across 511→0 checks the modular age comparison.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int TAG_W = 9;

    typedef logic [TAG_W-1:0] seq_t;

    typedef enum logic [1:0] {
        RING_HOLD,
        RING_TRIM,
        RING_ADVANCE
    } ring_op_e;

    // a strictly younger than b, modulo 2**TAG_W
    function automatic logic is_younger(seq_t a, seq_t b);
        seq_t d;
        d = a - b;
        return (d != '0) && !d[TAG_W-1];
    endfunction

endpackage

// File: rtl/lsq_ring.sv
module lsq_ring
    import lsq_pkg::*;
#(
    parameter int DEPTH = 130,
    parameter int RW    = 2,
    parameter int RN_W  = $clog2(RW + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_en,
    input  seq_t                      alloc_tag,
    input  logic [RN_W-1:0]           rel_n,
    input  logic                      flush_en,
    input  seq_t                      flush_tag,
    output seq_t [RW-1:0]             peek_tag,
    output logic [RW-1:0]             peek_vld,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [DEPTH-1:0]          busy
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    seq_t             tags [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [IW-1:0]    head, tail;
    logic [DEPTH-1:0] drop_mask;
    logic [CW-1:0]    drop_cnt;
    ring_op_e         op;
    seq_t             last_tag;

    function automatic logic [IW-1:0] wrap_add(logic [IW-1:0] idx, int unsigned k);
        int unsigned s;
        s = int'(idx) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return IW'(s);
    endfunction

    always_comb begin
        drop_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            drop_mask[i] = vld[i] && is_younger(tags[i], flush_tag);
            drop_cnt     = drop_cnt + CW'(drop_mask[i]);
        end
    end

    always_comb begin
        if (flush_en)                      op = RING_TRIM;
        else if (alloc_en || rel_n != '0)  op = RING_ADVANCE;
        else                               op = RING_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            vld   <= '0;
        end else begin
            unique case (op)
                RING_TRIM: begin
                    vld   <= vld & ~drop_mask;
                    tail  <= wrap_add(tail, DEPTH - int'(drop_cnt));
                    count <= count - drop_cnt;
                end
                RING_ADVANCE: begin
                    for (int k = 0; k < RW; k++)
                        if (k < int'(rel_n)) vld[wrap_add(head, k)] <= 1'b0;
                    if (alloc_en) vld[tail] <= 1'b1;
                    head  <= wrap_add(head, int'(rel_n));
                    tail  <= wrap_add(tail, alloc_en ? 1 : 0);
                    count <= count - CW'(rel_n) + CW'(alloc_en);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en && !flush_en) tags[tail] <= alloc_tag;
    end

    for (genvar k = 0; k < RW; k++) begin : g_peek
        assign peek_tag[k] = tags[wrap_add(head, k)];
        assign peek_vld[k] = count > CW'(k);
    end

    assign last_tag = tags[wrap_add(tail, DEPTH - 1)];
    assign busy     = vld;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && count == CW'(DEPTH)) |-> (rel_n != '0));

    assert_count_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_rel_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(rel_n) <= count);

    assert_issue_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && count != '0) |-> is_younger(alloc_tag, last_tag));

    assert_flush_trim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (count == '0) || !is_younger(last_tag, $past(flush_tag)));

endmodule

// File: rtl/lsq_release_sel.sv
module lsq_release_sel
    import lsq_pkg::*;
#(
    parameter int RW   = 2,
    parameter int RN_W = $clog2(RW + 1)
) (
    input  seq_t [RW-1:0]   ld_tag,
    input  logic [RW-1:0]   ld_vld,
    input  seq_t [RW-1:0]   st_tag,
    input  logic [RW-1:0]   st_vld,
    input  seq_t            bound,
    output logic [RN_W-1:0] ld_n,
    output logic [RN_W-1:0] st_n
);

    // merge both ring heads oldest-first; stop at the first op past the bound
    always_comb begin
        int   li, si;
        logic stop, ld_ok, st_ok, take_ld;
        li = 0;
        si = 0;
        stop = 1'b0;
        for (int k = 0; k < RW; k++) begin
            ld_ok   = ld_vld[li] && !is_younger(ld_tag[li], bound);
            st_ok   = st_vld[si] && !is_younger(st_tag[si], bound);
            take_ld = ld_ok && (!st_ok || is_younger(st_tag[si], ld_tag[li]));
            if (!stop) begin
                if (take_ld)     li = li + 1;
                else if (st_ok)  si = si + 1;
                else             stop = 1'b1;
            end
        end
        ld_n = RN_W'(li);
        st_n = RN_W'(si);
    end

endmodule

// File: rtl/lsq_late_alloc.sv
module lsq_late_alloc
    import lsq_pkg::*;
#(
    parameter int LQ_DEPTH = 130,
    parameter int SQ_DEPTH = 60,
    parameter int REL_PER_CYC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic                issue_is_store,
    input  logic [TAG_W-1:0]    issue_tag,
    output logic                issue_grant,
    input  logic [TAG_W-1:0]    nonspec_tag,
    input  logic                flush_valid,
    input  logic [TAG_W-1:0]    flush_tag,
    output logic [LQ_DEPTH-1:0] lq_busy,
    output logic [SQ_DEPTH-1:0] sq_busy,
    output logic                lq_full,
    output logic                sq_full
);

    localparam int RN_W = $clog2(REL_PER_CYC + 1);
    localparam int LCW  = $clog2(LQ_DEPTH + 1);
    localparam int SCW  = $clog2(SQ_DEPTH + 1);

    seq_t [REL_PER_CYC-1:0] ld_peek, st_peek;
    logic [REL_PER_CYC-1:0] ld_pv, st_pv;
    logic [LCW-1:0]         lq_count;
    logic [SCW-1:0]         sq_count;
    logic [RN_W-1:0]        sel_ld, sel_st, rel_ld, rel_st;
    logic                   ld_room, st_room, ld_alloc, st_alloc;

    lsq_release_sel #(.RW(REL_PER_CYC), .RN_W(RN_W)) u_sel (
        .ld_tag (ld_peek),
        .ld_vld (ld_pv),
        .st_tag (st_peek),
        .st_vld (st_pv),
        .bound  (nonspec_tag),
        .ld_n   (sel_ld),
        .st_n   (sel_st)
    );

    assign rel_ld = flush_valid ? '0 : sel_ld;
    assign rel_st = flush_valid ? '0 : sel_st;

    assign lq_full = (lq_count == LCW'(LQ_DEPTH));
    assign sq_full = (sq_count == SCW'(SQ_DEPTH));
    assign ld_room = !lq_full || (rel_ld != '0);
    assign st_room = !sq_full || (rel_st != '0);

    assign issue_grant = issue_valid && !flush_valid && (issue_is_store ? st_room : ld_room);
    assign ld_alloc    = issue_grant && !issue_is_store;
    assign st_alloc    = issue_grant && issue_is_store;

    lsq_ring #(.DEPTH(LQ_DEPTH), .RW(REL_PER_CYC), .RN_W(RN_W)) u_lq (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (ld_alloc),
        .alloc_tag (issue_tag),
        .rel_n     (rel_ld),
        .flush_en  (flush_valid),
        .flush_tag (flush_tag),
        .peek_tag  (ld_peek),
        .peek_vld  (ld_pv),
        .count     (lq_count),
        .busy      (lq_busy)
    );

    lsq_ring #(.DEPTH(SQ_DEPTH), .RW(REL_PER_CYC), .RN_W(RN_W)) u_sq (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (st_alloc),
        .alloc_tag (issue_tag),
        .rel_n     (rel_st),
        .flush_en  (flush_valid),
        .flush_tag (flush_tag),
        .peek_tag  (st_peek),
        .peek_vld  (st_pv),
        .count     (sq_count),
        .busy      (sq_busy)
    );

    assert_flush_nogrant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !issue_grant);

    assert_rate_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rel_ld) + int'(rel_st)) <= REL_PER_CYC);

    assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_full && issue_valid && !issue_is_store && !issue_grant) |=> lq_full);

endmodule

// File: tb/tb_lsq_late_alloc.sv
module tb_lsq_late_alloc;
    import lsq_pkg::*;

    localparam int LQ = 130;
    localparam int SQ = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_valid = 1'b0, issue_is_store = 1'b0;
    seq_t issue_tag = '0, nonspec_tag = '0, flush_tag = '0;
    logic flush_valid = 1'b0;
    logic issue_grant, lq_full, sq_full;
    logic [LQ-1:0] lq_busy;
    logic [SQ-1:0] sq_busy;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lsq_late_alloc #(.LQ_DEPTH(LQ), .SQ_DEPTH(SQ), .REL_PER_CYC(2)) dut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_is_store(issue_is_store), .issue_tag(issue_tag),
        .issue_grant(issue_grant), .nonspec_tag(nonspec_tag),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .lq_busy(lq_busy), .sq_busy(sq_busy), .lq_full(lq_full), .sq_full(sq_full)
    );

    task automatic chk(string req, string what, logic [255:0] got, logic [255:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [255:0] bit_at(int i);
        return 256'(1) << i;
    endfunction

    task automatic issue(logic st, int tag, logic exp_grant, string req);
        issue_valid    = 1'b1;
        issue_is_store = st;
        issue_tag      = seq_t'(tag);
        #1;
        chk(req, "issue_grant", 256'(issue_grant), 256'(exp_grant));
        tick();
        issue_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "lq_busy", 256'(lq_busy), '0);
        chk("R1", "sq_busy", 256'(sq_busy), '0);
        chk("R1", "full flags", 256'({lq_full, sq_full}), '0);
    endtask

    task automatic t_alloc();
        issue(1'b0, 1, 1'b1, "R2");
        chk("R2", "lq slot0", 256'(lq_busy), bit_at(0));
        issue(1'b1, 2, 1'b1, "R2");
        chk("R2", "sq slot0", 256'(sq_busy), bit_at(0));
        issue(1'b0, 3, 1'b1, "R2");
        chk("R2", "lq slots0-1", 256'(lq_busy), bit_at(0) | bit_at(1));
    endtask

    task automatic t_release_basic();
        nonspec_tag = 9'd2;
        tick();
        chk("R5", "lq after bound 2", 256'(lq_busy), bit_at(1));
        chk("R4", "sq after bound 2", 256'(sq_busy), '0);
        nonspec_tag = 9'd3;
        tick();
        chk("R4", "lq after bound 3", 256'(lq_busy), '0);
    endtask

    task automatic t_release_order();
        issue(1'b1, 4, 1'b1, "R2");
        issue(1'b1, 5, 1'b1, "R2");
        issue(1'b1, 6, 1'b1, "R2");
        issue(1'b0, 7, 1'b1, "R2");
        chk("R4", "lq held below bound", 256'(lq_busy), bit_at(2));
        nonspec_tag = 9'd7;
        tick();
        chk("R6", "sq two freed", 256'(sq_busy), bit_at(3));
        chk("R5", "younger load waits", 256'(lq_busy), bit_at(2));
        tick();
        chk("R5", "sq drained", 256'(sq_busy), '0);
        chk("R5", "lq drained", 256'(lq_busy), '0);
    endtask

    task automatic t_flush();
        issue(1'b0, 11, 1'b1, "R2");
        issue(1'b0, 12, 1'b1, "R2");
        issue(1'b0, 13, 1'b1, "R2");
        issue(1'b1, 14, 1'b1, "R2");
        issue(1'b0, 15, 1'b1, "R2");
        chk("R2", "lq before flush", 256'(lq_busy), bit_at(3) | bit_at(4) | bit_at(5) | bit_at(6));
        chk("R2", "sq before flush", 256'(sq_busy), bit_at(4));
        flush_valid = 1'b1;
        flush_tag   = 9'd12;
        nonspec_tag = 9'd11;
        issue(1'b0, 16, 1'b0, "R8");
        flush_valid = 1'b0;
        chk("R8", "lq trimmed, no release", 256'(lq_busy), bit_at(3) | bit_at(4));
        chk("R8", "sq trimmed", 256'(sq_busy), '0);
        issue(1'b0, 17, 1'b1, "R8");
        chk("R8", "rewound slot reused", 256'(lq_busy), bit_at(4) | bit_at(5));
        nonspec_tag = 9'd17;
        tick();
        chk("R6", "lq empty", 256'(lq_busy), '0);
    endtask

    task automatic t_full();
        logic [255:0] all_lq;
        all_lq = (256'(1) << LQ) - 256'(1);
        for (int t = 18; t < 18 + LQ; t++) begin
            issue_valid = 1'b1; issue_is_store = 1'b0; issue_tag = seq_t'(t);
            tick();
        end
        issue_valid = 1'b0;
        chk("R3", "lq_full", 256'(lq_full), 256'(1));
        chk("R3", "lq all busy", 256'(lq_busy), all_lq);
        issue(1'b0, 148, 1'b0, "R3");
        chk("R3", "lq unchanged after refusal", 256'(lq_busy), all_lq);
        issue(1'b1, 148, 1'b1, "R3");
        chk("R3", "store taken while lq full", 256'(sq_busy), bit_at(4));
        nonspec_tag = 9'd18;
        issue(1'b0, 149, 1'b1, "R7");
        chk("R7", "lq still full", 256'(lq_full), 256'(1));
        chk("R7", "lq all busy", 256'(lq_busy), all_lq);
        nonspec_tag = 9'd149;
        repeat (70) tick();
        chk("R6", "lq drained", 256'(lq_busy), '0);
        chk("R6", "sq drained", 256'(sq_busy), '0);
    endtask

    task automatic t_wrap();
        nonspec_tag = 9'd400;
        tick();
        issue(1'b0, 510, 1'b1, "R9");
        issue(1'b0, 511, 1'b1, "R9");
        issue(1'b0, 0, 1'b1, "R9");
        issue(1'b0, 1, 1'b1, "R9");
        chk("R9", "held across wrap", 256'(lq_busy), bit_at(7) | bit_at(8) | bit_at(9) | bit_at(10));
        nonspec_tag = 9'd511;
        tick();
        tick();
        chk("R9", "only pre-wrap freed", 256'(lq_busy), bit_at(9) | bit_at(10));
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        t_reset();
        t_alloc();
        t_release_basic();
        t_release_order();
        t_flush();
        t_full();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule